// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block merges the chip's two reset sources, a board-level reset pin and a watchdog request, into one internal reset for the processor and its peripherals. Any reset source forces the internal reset high. The reset is held until four conditions are true together: the pin is released, the oscillator reports that it is running, a fixed number of oscillator clocks has passed with that report steady, and flash initialisation has finished. On the first cycle after release a one-cycle pulse tells the processor to fetch from address 0.

The same clock count also guards exit from power-down. While the processor is in power-down or waking up, a hold output keeps it stalled without resetting it. A small register records the cause of the most recent reset. The pin input is filtered, so short low glitches have no effect. The oscillator amplitude check and the pin's analog conditioning are outside the block. Both arrive as digital inputs in the `clk` domain.

Top module: `rstwake_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sys_rst`=1, `cpu_hold`=1, `vec0_start`=0 and `rst_cause`=2'b00 (power-on).
- R2: `wdt_rst` sampled high on a clock edge sets `sys_rst`=1 from that edge. If the pin is not active at the same time, `rst_cause` becomes 2'b10.
- R3: The pin `ext_rst_n` passes through a two-flop synchroniser. It becomes an active reset only after its synchronised level has been low for FILT_LEN consecutive clocks (default 4). It then sets `sys_rst`=1 and `rst_cause`=2'b01. A low pulse of FILT_LEN-1 clocks changes neither output.
- R4: Counting edges are edges that sample `osc_ok`=1 with no active reset source. While reset is held, `sys_rst` falls on the edge after WAKE_CYC consecutive counting edges (default 4096) and no earlier.
- R5: `sys_rst` stays high while `flash_done`=0, even after the count has completed. It falls on the first edge that samples `flash_done`=1.
- R6: While the filtered pin stays active, `sys_rst` stays high for as long as it is held.
- R7: `vec0_start` is high for exactly one cycle, the first cycle in which `sys_rst` is low after a reset. It is never raised on return from power-down.
- R8: `pd_req` sampled high while running sets `cpu_hold`=1 from that edge and leaves `sys_rst`=0. Outside the running state `pd_req` has no effect.
- R9: In power-down, an edge that samples `pd_wake`=1 starts the same WAKE_CYC count. `cpu_hold` falls WAKE_CYC+1 edges after that edge. `pd_wake` has no effect while running.
- R10: When the filtered pin and the watchdog are active on the same edge, `rst_cause` becomes 2'b01 (the pin wins).
- R11: `cpu_hold` is high whenever `sys_rst` is high.
- R12: An edge that samples `osc_ok`=0 during a count restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n | input | 1 | Reset pin, active low, unfiltered |
| wdt_rst | input | 1 | Watchdog reset request, active high |
| osc_ok | input | 1 | Oscillator running indication |
| flash_done | input | 1 | Flash initialisation complete |
| pd_req | input | 1 | Request to enter power-down |
| pd_wake | input | 1 | Wake event while powered down |
| sys_rst | output | 1 | Internal reset, active high, registered |
| cpu_hold | output | 1 | Processor stall: reset, power-down or wake count |
| vec0_start | output | 1 | One-cycle pulse: begin execution at address 0 |
| rst_cause | output | 2 | Last reset cause: 00 power-on, 01 pin, 10 watchdog |

## Verification
On every cycle, the assertions check the following:
- A watchdog request or an active filtered pin forces reset, and the matching cause is recorded.
- Reset never falls without flash and oscillator readiness on the previous edge.
- The start pulse is one cycle long and follows a held reset.
- `cpu_hold` covers reset.
- The cause code is legal.

Some behaviours can only be shown by the bench's scenarios, which count edges from a known point:
- The exact length of the wake-up count.
- The restart of the count when the oscillator drops.
- The boundary between an ignored glitch and an accepted pin pulse.
- That power-down exit reuses the count without raising the start pulse.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } rw_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_PIN = 2'b01,
    CAUSE_WDT = 2'b10
  } rw_cause_e;

endpackage

// File: rtl/rstwake_glitch.sv
// Synchronises the reset pin and accepts it only after a run of low samples.
module rstwake_glitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic active
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(FILT_LEN);

  logic          sync1, sync2;
  logic [CW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      low_run <= '0;
    end else begin
      sync1 <= pin_n;
      sync2 <= sync1;
      if (sync2)
        low_run <= '0;
      else if (low_run != RUN_MAX)
        low_run <= low_run + 1'b1;
    end
  end

  assign active = (low_run == RUN_MAX);
endmodule

// File: rtl/rstwake_timer.sv
// Saturating wake-up counter shared by reset release and power-down exit.
module rstwake_timer #(
  parameter int WAKE_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  output logic done
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (enable && cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
  import rstwake_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int WAKE_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_rst_n,
  input  logic       wdt_rst,
  input  logic       osc_ok,
  input  logic       flash_done,
  input  logic       pd_req,
  input  logic       pd_wake,
  output logic       sys_rst,
  output logic       cpu_hold,
  output logic       vec0_start,
  output logic [1:0] rst_cause
);
  rw_state_e state, state_nx;
  logic      pin_act, cnt_done, src_evt, cnt_clear, cnt_en;

  rstwake_glitch #(.FILT_LEN(FILT_LEN)) u_glitch (
    .clk    (clk),
    .rst    (rst),
    .pin_n  (ext_rst_n),
    .active (pin_act)
  );

  assign src_evt   = pin_act || wdt_rst;
  assign cnt_clear = src_evt || !osc_ok || state == ST_RUN || state == ST_SLEEP;
  assign cnt_en    = (state == ST_HOLD) || (state == ST_WAKE);

  rstwake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (cnt_clear),
    .enable (cnt_en),
    .done   (cnt_done)
  );

  always_comb begin
    state_nx = state;
    if (src_evt) begin
      state_nx = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD:  if (cnt_done && osc_ok && flash_done) state_nx = ST_RUN;
        ST_RUN:   if (pd_req)                           state_nx = ST_SLEEP;
        ST_SLEEP: if (pd_wake)                          state_nx = ST_WAKE;
        ST_WAKE:  if (cnt_done && osc_ok)               state_nx = ST_RUN;
        default:                                        state_nx = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HOLD;
      sys_rst    <= 1'b1;
      cpu_hold   <= 1'b1;
      vec0_start <= 1'b0;
      rst_cause  <= CAUSE_POR;
    end else begin
      state      <= state_nx;
      sys_rst    <= (state_nx == ST_HOLD);
      cpu_hold   <= (state_nx != ST_RUN);
      vec0_start <= (state == ST_HOLD) && (state_nx == ST_RUN);
      if (pin_act)
        rst_cause <= CAUSE_PIN;
      else if (wdt_rst)
        rst_cause <= CAUSE_WDT;
    end
  end
endmodule

// File: rtl/rstwake_chk.sv
module rstwake_chk (
  input logic       clk,
  input logic       rst,
  input logic       wdt_rst,
  input logic       osc_ok,
  input logic       flash_done,
  input logic       pin_act,
  input logic       sys_rst,
  input logic       cpu_hold,
  input logic       vec0_start,
  input logic [1:0] rst_cause
);
  p_wdt_forces_r2: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |=> sys_rst);

  p_wdt_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst && !pin_act) |=> (rst_cause == 2'b10));

  p_pin_cause_r10: assert property (@(posedge clk) disable iff (rst)
    pin_act |=> (sys_rst && rst_cause == 2'b01));

  p_release_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> ($past(flash_done) && $past(osc_ok)));

  p_vec0_single_r7: assert property (@(posedge clk) disable iff (rst)
    vec0_start |=> !vec0_start);

  p_vec0_after_rst_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(vec0_start) |-> (!sys_rst && !cpu_hold && $past(sys_rst)));

  p_hold_covers_r11: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> cpu_hold);

  p_cause_legal_r1: assert property (@(posedge clk) disable iff (rst)
    rst_cause != 2'b11);
endmodule

bind rstwake_ctrl rstwake_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wdt_rst    (wdt_rst),
  .osc_ok     (osc_ok),
  .flash_done (flash_done),
  .pin_act    (pin_act),
  .sys_rst    (sys_rst),
  .cpu_hold   (cpu_hold),
  .vec0_start (vec0_start),
  .rst_cause  (rst_cause)
);

// File: tb/rstwake_ctrl_tb.sv
module rstwake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int WAKE = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_n = 1'b1, wdt_rst = 1'b0, osc_ok = 1'b0, flash_done = 1'b1;
  logic pd_req = 1'b0, pd_wake = 1'b0;
  logic sys_rst, cpu_hold, vec0_start;
  logic [1:0] rst_cause;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstwake_ctrl #(.FILT_LEN(FILT), .WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_rst(wdt_rst),
    .osc_ok(osc_ok), .flash_done(flash_done), .pd_req(pd_req), .pd_wake(pd_wake),
    .sys_rst(sys_rst), .cpu_hold(cpu_hold), .vec0_start(vec0_start),
    .rst_cause(rst_cause)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic pulse_wdt();
    wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
  endtask

  task automatic t_power_on();
    step(3);
    check(sys_rst, 1, "R1 sys_rst in reset");
    check(cpu_hold, 1, "R1 cpu_hold in reset");
    check(vec0_start, 0, "R1 vec0 in reset");
    check(rst_cause, 0, "R1 cause in reset");
    rst = 1'b0; step(5);
    check(sys_rst, 1, "R4 held without osc_ok");
    check(rst_cause, 0, "R1 cause after reset");
    osc_ok = 1'b1; step(WAKE);
    check(sys_rst, 1, "R4 held at count end");
    step(1);
    check(sys_rst, 0, "R4 released after count");
    check(vec0_start, 1, "R7 vec0 pulse");
    step(1);
    check(vec0_start, 0, "R7 vec0 one cycle");
  endtask

  task automatic t_watchdog();
    pulse_wdt();
    check(sys_rst, 1, "R2 wdt asserts reset");
    check(cpu_hold, 1, "R11 hold during reset");
    check(rst_cause, 2, "R2 wdt cause");
    step(WAKE);
    check(sys_rst, 1, "R4 wdt count not done");
    step(1);
    check(sys_rst, 0, "R4 wdt release");
  endtask

  task automatic t_flash_wait();
    flash_done = 1'b0; pulse_wdt(); step(WAKE + 5);
    check(sys_rst, 1, "R5 blocked by flash");
    flash_done = 1'b1; step(1);
    check(sys_rst, 0, "R5 release on flash_done");
  endtask

  task automatic t_osc_drop();
    pulse_wdt(); step(WAKE - 3);
    osc_ok = 1'b0; step(1); osc_ok = 1'b1;
    step(WAKE);
    check(sys_rst, 1, "R12 count restarted");
    step(1);
    check(sys_rst, 0, "R12 release after restart");
  endtask

  task automatic t_glitch();
    ext_rst_n = 1'b0; step(FILT - 1); ext_rst_n = 1'b1; step(8);
    check(sys_rst, 0, "R3 short glitch ignored");
    check(rst_cause, 2, "R3 cause unchanged by glitch");
    ext_rst_n = 1'b0; step(FILT); ext_rst_n = 1'b1; step(8);
    check(sys_rst, 1, "R3 pulse accepted");
    check(rst_cause, 1, "R3 pin cause");
    step(WAKE + 10);
    check(sys_rst, 0, "R3 release after pin pulse");
  endtask

  task automatic t_pin_hold_and_priority();
    ext_rst_n = 1'b0; step(8);
    pulse_wdt();
    check(rst_cause, 1, "R10 pin wins over wdt");
    step(WAKE * 3);
    check(sys_rst, 1, "R6 held while pin low");
    ext_rst_n = 1'b1; step(WAKE + 10);
    check(sys_rst, 0, "R6 release after pin high");
    check(rst_cause, 1, "R10 cause kept");
  endtask

  task automatic t_power_down();
    pd_wake = 1'b1; step(2); pd_wake = 1'b0;
    check(cpu_hold, 0, "R9 wake ignored in run");
    pd_req = 1'b1; step(1); pd_req = 1'b0;
    check(cpu_hold, 1, "R8 hold in power-down");
    check(sys_rst, 0, "R8 no reset in power-down");
    step(WAKE + 20);
    check(cpu_hold, 1, "R8 stays asleep");
    pd_wake = 1'b1; step(1); pd_wake = 1'b0;
    step(WAKE);
    check(cpu_hold, 1, "R9 hold during wake count");
    step(1);
    check(cpu_hold, 0, "R9 resumed after count");
    check(vec0_start, 0, "R7 no vec0 on wake");
    check(sys_rst, 0, "R9 no reset on wake");
  endtask

  initial begin
    t_power_on();
    t_watchdog();
    t_flash_wait();
    t_osc_drop();
    t_glitch();
    t_pin_hold_and_priority();
    t_power_down();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule